// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host move bytes into and out of a local packet RAM through one data port. It does not map the RAM into the host's address space. The host first programs a 16-bit pointer and a 16-bit byte count. It loads each of them as two byte-wide register writes, one per half. Every data-port access then moves one, two or four bytes:

- Each moved byte is stored at, or fetched from, the pointer.
- After each byte, the pointer advances and wraps inside a receive ring bounded by a start page and a stop page.
- After each byte, the count drops by one.

When the count runs out, the block emits a one-cycle completion pulse, which the surrounding interrupt logic turns into an interrupt cause.

A narrow, strobe-based register port programs the ring bounds, the word-mode flag, the pointer and the count, and takes command bytes. A separate data port carries reads and writes of width 8, 16 or 32 bits. Multi-byte accesses are serialised into one RAM byte per clock. Read data is gathered into a 32-bit result, and `dp_rvalid` marks when that result is complete. While an access is in progress `dp_busy` is high, and any new strobe is ignored.

Top module: `rdma_port`

## Requirements
- R1: After reset the pointer and count read 0, `dp_busy`, `dp_rvalid` and `rdc_pulse` are low, word mode is off, and the ring bounds are start page 0x40 and stop page 0x80. So a byte written at pointer 0x7FFF leaves the pointer at 0x4000.
- R2: Register offsets on `reg_addr` are 0 command, 1 ring start page, 2 ring stop page, 3 configuration (bit 0 = word mode), 4/5 pointer low/high byte, and 6/7 count low/high byte. A write to one half of the pointer or count leaves the other half unchanged.
- R3: Each moved byte advances the pointer and decrements the count. A written byte is stored at the pointer value held before the advance. The RAM holds 2^RAM_AW bytes (default 2048) and is indexed by the low RAM_AW pointer bits.
- R4: A read returns the RAM byte at the pointer value held before the advance.
- R5: When a decrement brings the count to zero, `rdc_pulse` is high for exactly one cycle, starting at the same edge at which the count becomes 0.
- R6: When the advanced pointer is at or above stop page × 256, (start page − stop page) × 256 is added to it. For example, with start 0x40 and stop 0x42 the pointer steps 0x41FF → 0x4000.
- R7: `dp_size` 0 moves one byte. `dp_size` 1 moves two bytes, low byte first, when word mode is set, and one byte otherwise.
- R8: `dp_size` 2 or 3 moves four bytes, least significant byte first. Byte k uses `dp_wdata[8k+7:8k]` and lands in `dp_rdata[8k+7:8k]`.
- R9: A write byte whose pointer is above 0x0010 and below 0x4000 is discarded. The RAM, the pointer and the count stay unchanged, and the access still takes its full number of cycles. Pointer 0x0010 and pointer 0x4000 are both writable.
- R10: A command write with bits [4:3] nonzero and bit 0 clear, while the count is zero, produces an `rdc_pulse` at the next edge. A command write with bit 0 set, or with bits [4:3] both zero, or made while the count is nonzero, does not.
- R11: The count never decrements below zero. A byte moved at count 0 still advances the pointer but produces no pulse.
- R12: An access is accepted at an edge where `dp_busy` is low. Its n bytes are handled in the n cycles that follow, with `dp_busy` high. For a write, `dp_busy` falls at the n-th edge. For a read, `dp_busy` falls at the (n+1)-th edge, at which `dp_rvalid` rises for one cycle with all n bytes present and higher lanes zero. A strobe seen while `dp_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write byte |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wr | input | 1 | Data-port write strobe |
| dp_size | input | 2 | Access width code |
| dp_wdata | input | 32 | Data-port write data |
| dp_rdata | output | 32 | Gathered read data |
| dp_rvalid | output | 1 | Read result complete, one cycle |
| dp_busy | output | 1 | Access in progress |
| cur_addr | output | 16 | Current pointer |
| cur_count | output | 16 | Current remaining byte count |
| rdc_pulse | output | 1 | Transfer-complete cause, one cycle |

## Verification
A wrong pointer step or a broken ring wrap shows up on `cur_addr` at the edge after the faulty byte. It later shows up as stale or misplaced bytes on `dp_rdata` when the same area is read back. A miscounted length shows on `cur_count` right away, and as a missing, doubled or early `rdc_pulse` within one cycle of the byte that should have ended the transfer. A lane or sequencing fault stays hidden until the next read of that area. It then appears exactly n+1 edges after acceptance, when `dp_rvalid` rises with the wrong byte order or with the pulse one cycle off.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  localparam int BYTE_W  = 8;
  localparam int PTR_W   = 2 * BYTE_W;
  localparam int LANES   = 4;
  localparam int LANE_IW = $clog2(LANES);
  localparam int DATA_W  = LANES * BYTE_W;
  localparam int LEFT_W  = $clog2(LANES) + 1;

  typedef enum logic [2:0] {
    RG_CMD    = 3'd0,
    RG_RING_S = 3'd1,
    RG_RING_E = 3'd2,
    RG_CFG    = 3'd3,
    RG_PTR_L  = 3'd4,
    RG_PTR_H  = 3'd5,
    RG_LEN_L  = 3'd6,
    RG_LEN_H  = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    XFER_B8   = 2'd0,
    XFER_B16  = 2'd1,
    XFER_B32  = 2'd2,
    XFER_B32X = 2'd3
  } xfer_size_e;

  typedef struct packed {
    logic ptr_lo;
    logic ptr_hi;
    logic len_lo;
    logic len_hi;
  } ptr_load_t;

endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RST_START = 8'h40,
  parameter logic [BYTE_W-1:0] RST_STOP  = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] start_pg,
  output logic [BYTE_W-1:0] stop_pg,
  output logic              word_mode,
  output ptr_load_t         ld,
  output logic              cmd_kick
);

  reg_sel_e          sel;
  logic [BYTE_W-1:0] start_q, start_n;
  logic [BYTE_W-1:0] stop_q, stop_n;
  logic              word_q, word_n;
  logic              cfg_en;

  assign sel = reg_sel_e'(reg_addr);

  always_comb begin
    start_n = start_q;
    stop_n  = stop_q;
    word_n  = word_q;
    if (reg_wr) begin
      unique case (sel)
        RG_RING_S: start_n = reg_wdata;
        RG_RING_E: stop_n  = reg_wdata;
        RG_CFG:    word_n  = reg_wdata[0];
        default:   ;
      endcase
    end
  end

  assign cfg_en = reg_wr && ((sel == RG_RING_S) || (sel == RG_RING_E) || (sel == RG_CFG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= RST_START;
      stop_q  <= RST_STOP;
      word_q  <= 1'b0;
    end else if (cfg_en) begin
      start_q <= start_n;
      stop_q  <= stop_n;
      word_q  <= word_n;
    end
  end

  always_comb begin
    ld.ptr_lo = reg_wr && (sel == RG_PTR_L);
    ld.ptr_hi = reg_wr && (sel == RG_PTR_H);
    ld.len_lo = reg_wr && (sel == RG_LEN_L);
    ld.len_hi = reg_wr && (sel == RG_LEN_H);
  end

  // remote command: either DMA direction bit set and the stop bit clear
  assign cmd_kick = reg_wr && (sel == RG_CMD) && (|reg_wdata[4:3]) && !reg_wdata[0];

  assign start_pg  = start_q;
  assign stop_pg   = stop_q;
  assign word_mode = word_q;

endmodule

// File: rtl/rdma_ptr.sv
module rdma_ptr
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ptr_load_t         ld,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] start_pg,
  input  logic [BYTE_W-1:0] stop_pg,
  input  logic              step,
  output logic [PTR_W-1:0]  addr,
  output logic [PTR_W-1:0]  count,
  output logic              zero_hit
);

  logic [PTR_W-1:0] addr_q, addr_n;
  logic [PTR_W-1:0] cnt_q, cnt_n;
  logic [PTR_W:0]   inc;
  logic [PTR_W-1:0] ring_lo, ring_hi, stepped, cnt_dec;
  logic             addr_en, cnt_en;

  assign ring_lo = {start_pg, {BYTE_W{1'b0}}};
  assign ring_hi = {stop_pg, {BYTE_W{1'b0}}};
  assign inc     = {1'b0, addr_q} + (PTR_W + 1)'(1);

  always_comb begin
    if (inc >= {1'b0, ring_hi}) stepped = inc[PTR_W-1:0] + (ring_lo - ring_hi);
    else                        stepped = inc[PTR_W-1:0];
  end

  assign cnt_dec  = (cnt_q != '0) ? (cnt_q - PTR_W'(1)) : cnt_q;
  assign zero_hit = step && (cnt_q == PTR_W'(1));

  always_comb begin
    addr_n = addr_q;
    if (ld.ptr_lo)      addr_n = {addr_q[PTR_W-1:BYTE_W], wdata};
    else if (ld.ptr_hi) addr_n = {wdata, addr_q[BYTE_W-1:0]};
    else if (step)      addr_n = stepped;
  end

  always_comb begin
    cnt_n = cnt_q;
    if (ld.len_lo)      cnt_n = {cnt_q[PTR_W-1:BYTE_W], wdata};
    else if (ld.len_hi) cnt_n = {wdata, cnt_q[BYTE_W-1:0]};
    else if (step)      cnt_n = cnt_dec;
  end

  assign addr_en = ld.ptr_lo || ld.ptr_hi || step;
  assign cnt_en  = ld.len_lo || ld.len_hi || step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign addr  = addr_q;
  assign count = cnt_q;

endmodule

// File: rtl/rdma_ram.sv
module rdma_ram
  import rdma_pkg::*;
#(
  parameter int RAM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [RAM_AW-1:0] idx,
  input  logic [BYTE_W-1:0] wd,
  output logic [BYTE_W-1:0] q
);

  localparam int DEPTH = 1 << RAM_AW;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] q_q;

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= '0;
    else if (re) q_q <= mem[idx];
  end

  assign q = q_q;

endmodule

// File: rtl/rdma_seq.sv
module rdma_seq
  import rdma_pkg::*;
#(
  parameter logic [PTR_W-1:0] UNMAP_LO = 16'h0010,
  parameter logic [PTR_W-1:0] UNMAP_HI = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dp_rd,
  input  logic              dp_wr,
  input  logic [1:0]        dp_size,
  input  logic [DATA_W-1:0] dp_wdata,
  input  logic              word_mode,
  input  logic [PTR_W-1:0]  addr,
  input  logic [BYTE_W-1:0] ram_q,
  output logic              ram_we,
  output logic              ram_re,
  output logic [BYTE_W-1:0] ram_wd,
  output logic              step,
  output logic              busy,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  xfer_size_e        sz;
  logic [LEFT_W-1:0] nbytes;
  logic              accept, unmapped, last;

  logic               act_q, act_n;
  logic               rd_q, rd_n;
  logic [LEFT_W-1:0]  left_q, left_n;
  logic [LANE_IW-1:0] lane_q, lane_n;
  logic [DATA_W-1:0]  wbuf_q, wbuf_n;
  logic               capv_q, capv_n;
  logic [LANE_IW-1:0] capl_q, capl_n;
  logic               capz_q, capz_n;
  logic [DATA_W-1:0]  rdata_q, rdata_n;
  logic               rvalid_q, rvalid_n;
  logic               ctl_en;

  assign sz = xfer_size_e'(dp_size);

  always_comb begin
    unique case (sz)
      XFER_B8:  nbytes = LEFT_W'(1);
      XFER_B16: nbytes = word_mode ? LEFT_W'(2) : LEFT_W'(1);
      default:  nbytes = LEFT_W'(LANES);
    endcase
  end

  assign busy     = act_q || capv_q;
  assign accept   = !busy && (dp_rd || dp_wr);
  assign unmapped = (addr > UNMAP_LO) && (addr < UNMAP_HI);
  assign last     = (left_q == LEFT_W'(1));

  assign ram_wd = wbuf_q[{lane_q, 3'b000} +: BYTE_W];
  assign ram_we = act_q && !rd_q && !unmapped;
  assign ram_re = act_q && rd_q;
  assign step   = act_q && (rd_q || !unmapped);

  always_comb begin
    act_n    = act_q;
    rd_n     = rd_q;
    left_n   = left_q;
    lane_n   = lane_q;
    wbuf_n   = wbuf_q;
    capv_n   = act_q && rd_q;
    capl_n   = lane_q;
    capz_n   = last;
    rdata_n  = rdata_q;
    rvalid_n = capv_q && capz_q;
    if (capv_q) rdata_n[{capl_q, 3'b000} +: BYTE_W] = ram_q;
    if (accept) begin
      act_n  = 1'b1;
      rd_n   = dp_rd;
      left_n = nbytes;
      lane_n = '0;
      wbuf_n = dp_wdata;
      if (dp_rd) rdata_n = '0;
    end else if (act_q) begin
      left_n = left_q - LEFT_W'(1);
      lane_n = lane_q + LANE_IW'(1);
      if (last) act_n = 1'b0;
    end
  end

  assign ctl_en = accept || act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      left_q <= '0;
      lane_q <= '0;
      wbuf_q <= '0;
    end else if (ctl_en) begin
      act_q  <= act_n;
      rd_q   <= rd_n;
      left_q <= left_n;
      lane_q <= lane_n;
      wbuf_q <= wbuf_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capv_q   <= 1'b0;
      capl_q   <= '0;
      capz_q   <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      capv_q   <= capv_n;
      capl_q   <= capl_n;
      capz_q   <= capz_n;
      rdata_q  <= rdata_n;
      rvalid_q <= rvalid_n;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int               RAM_AW    = 11,
  parameter logic [7:0]       RST_START = 8'h40,
  parameter logic [7:0]       RST_STOP  = 8'h80,
  parameter logic [15:0]      UNMAP_LO  = 16'h0010,
  parameter logic [15:0]      UNMAP_HI  = 16'h4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic        dp_rd,
  input  logic        dp_wr,
  input  logic [1:0]  dp_size,
  input  logic [31:0] dp_wdata,
  output logic [31:0] dp_rdata,
  output logic        dp_rvalid,
  output logic        dp_busy,
  output logic [15:0] cur_addr,
  output logic [15:0] cur_count,
  output logic        rdc_pulse
);

  logic [1:0]        rst_pipe;
  logic              srst_n;
  logic [BYTE_W-1:0] start_pg, stop_pg;
  logic              word_mode, cmd_kick, zero_hit;
  ptr_load_t         ld;
  logic [PTR_W-1:0]  addr, count;
  logic              step, ram_we, ram_re;
  logic [BYTE_W-1:0] ram_wd, ram_q;
  logic              rdc_q, rdc_n;

  // reset: asserts at once, leaves after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  rdma_regs #(
    .RST_START (RST_START),
    .RST_STOP  (RST_STOP)
  ) i_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .start_pg  (start_pg),
    .stop_pg   (stop_pg),
    .word_mode (word_mode),
    .ld        (ld),
    .cmd_kick  (cmd_kick)
  );

  rdma_ptr i_ptr (
    .clk      (clk),
    .rst_n    (srst_n),
    .ld       (ld),
    .wdata    (reg_wdata),
    .start_pg (start_pg),
    .stop_pg  (stop_pg),
    .step     (step),
    .addr     (addr),
    .count    (count),
    .zero_hit (zero_hit)
  );

  rdma_seq #(
    .UNMAP_LO (UNMAP_LO),
    .UNMAP_HI (UNMAP_HI)
  ) i_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .dp_rd     (dp_rd),
    .dp_wr     (dp_wr),
    .dp_size   (dp_size),
    .dp_wdata  (dp_wdata),
    .word_mode (word_mode),
    .addr      (addr),
    .ram_q     (ram_q),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_wd    (ram_wd),
    .step      (step),
    .busy      (dp_busy),
    .rdata     (dp_rdata),
    .rvalid    (dp_rvalid)
  );

  rdma_ram #(
    .RAM_AW (RAM_AW)
  ) i_ram (
    .clk   (clk),
    .rst_n (srst_n),
    .we    (ram_we),
    .re    (ram_re),
    .idx   (addr[RAM_AW-1:0]),
    .wd    (ram_wd),
    .q     (ram_q)
  );

  assign rdc_n = zero_hit || (cmd_kick && (count == '0));

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rdc_q <= 1'b0;
    else         rdc_q <= rdc_n;
  end

  assign rdc_pulse = rdc_q;
  assign cur_addr  = addr;
  assign cur_count = count;

endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk
  import rdma_pkg::*;
#(
  parameter logic [15:0] UNMAP_LO = 16'h0010,
  parameter logic [15:0] UNMAP_HI = 16'h4000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [15:0] cur_addr,
  input logic [15:0] cur_count,
  input logic        step,
  input logic        ram_we,
  input logic [7:0]  start_pg,
  input logic [7:0]  stop_pg,
  input logic        rdc_pulse,
  input logic        dp_rvalid,
  input logic        dp_busy
);

  logic len_ld, ptr_ld;
  assign len_ld = reg_wr && ((reg_addr == RG_LEN_L) || (reg_addr == RG_LEN_H));
  assign ptr_ld = reg_wr && ((reg_addr == RG_PTR_L) || (reg_addr == RG_PTR_H));

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(step) && !$past(ptr_ld) && !$past(len_ld)) |-> ($stable(cur_addr) && $stable(cur_count))) // R3
    else $error("pointer or count moved without a byte step");

  AST_RDC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdc_pulse && !$past(len_ld)) |-> (cur_count == 16'h0)) // R5
    else $error("completion pulse with nonzero count");

  AST_RING_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step) && !$past(ptr_ld) && ($past(start_pg) < $past(stop_pg)) &&
     ($past(cur_addr) >= {$past(start_pg), 8'h00}) && ($past(cur_addr) < {$past(stop_pg), 8'h00}))
    |-> ((cur_addr >= {$past(start_pg), 8'h00}) && (cur_addr < {$past(stop_pg), 8'h00}))) // R6
    else $error("pointer left the ring");

  AST_NO_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !((cur_addr > UNMAP_LO) && (cur_addr < UNMAP_HI))) // R9
    else $error("RAM write inside the discarded window");

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cur_count) == 16'h0) && !$past(len_ld)) |-> (cur_count == 16'h0)) // R11
    else $error("count underflow");

  AST_RVALID_END: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rvalid |-> (!dp_busy && $past(dp_busy))) // R12
    else $error("read result outside end of access");

endmodule

bind rdma_port rdma_port_chk #(
  .UNMAP_LO (UNMAP_LO),
  .UNMAP_HI (UNMAP_HI)
) i_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .cur_addr  (cur_addr),
  .cur_count (cur_count),
  .step      (step),
  .ram_we    (ram_we),
  .start_pg  (start_pg),
  .stop_pg   (stop_pg),
  .rdc_pulse (rdc_pulse),
  .dp_rvalid (dp_rvalid),
  .dp_busy   (dp_busy)
);

// File: tb/test_rdma_port.sv
`timescale 1ns/1ps
module test_rdma_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        dp_rd = 1'b0;
  logic        dp_wr = 1'b0;
  logic [1:0]  dp_size = '0;
  logic [31:0] dp_wdata = '0;
  logic [31:0] dp_rdata;
  logic        dp_rvalid, dp_busy, rdc_pulse;
  logic [15:0] cur_addr, cur_count;

  int n_chk = 0;
  int n_bad = 0;
  logic last_rdc;

  logic [7:0]  sh_mem [2048];
  logic [15:0] m_addr = '0;
  logic [15:0] m_cnt = '0;
  logic [7:0]  m_start = 8'h40;
  logic [7:0]  m_stop = 8'h80;
  logic        m_word = 1'b0;

  always #2.5 clk = ~clk;

  rdma_port i_rdma_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dp_rd     (dp_rd),
    .dp_wr     (dp_wr),
    .dp_size   (dp_size),
    .dp_wdata  (dp_wdata),
    .dp_rdata  (dp_rdata),
    .dp_rvalid (dp_rvalid),
    .dp_busy   (dp_busy),
    .cur_addr  (cur_addr),
    .cur_count (cur_count),
    .rdc_pulse (rdc_pulse)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    last_rdc = rdc_pulse;
    case (a)
      3'd1: m_start = d;
      3'd2: m_stop = d;
      3'd3: m_word = d[0];
      3'd4: m_addr[7:0] = d;
      3'd5: m_addr[15:8] = d;
      3'd6: m_cnt[7:0] = d;
      3'd7: m_cnt[15:8] = d;
      default: ;
    endcase
  endtask

  task automatic set_ptr(input logic [15:0] a, input logic [15:0] c);
    wr_reg(3'd4, a[7:0]); wr_reg(3'd5, a[15:8]);
    wr_reg(3'd6, c[7:0]); wr_reg(3'd7, c[15:8]);
  endtask

  task automatic model_byte(input bit rd, input logic [7:0] d, output logic [7:0] q, inout int p);
    logic [16:0] nx;
    q = '0;
    if (!rd && m_addr > 16'h0010 && m_addr < 16'h4000) return;
    if (rd) q = sh_mem[m_addr[10:0]];
    else    sh_mem[m_addr[10:0]] = d;
    nx = {1'b0, m_addr} + 17'd1;
    if (nx >= {1'b0, m_stop, 8'h00}) nx = nx + {1'b0, m_start, 8'h00} - {1'b0, m_stop, 8'h00};
    m_addr = nx[15:0];
    if (m_cnt != 16'h0) begin
      m_cnt = m_cnt - 16'd1;
      if (m_cnt == 16'h0) p++;
    end
  endtask

  task automatic xfer(input bit rd, input logic [1:0] sz, input logic [31:0] wd, input string req);
    int n, exp_p, got_p, tot;
    logic [31:0] exp_q;
    logic [7:0] b;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? (m_word ? 2 : 1) : 4;
    exp_q = '0; exp_p = 0; got_p = 0;
    for (int i = 0; i < n; i++) begin
      model_byte(rd, wd[8*i +: 8], b, exp_p);
      if (rd) exp_q[8*i +: 8] = b;
    end
    tot = n + (rd ? 1 : 0);
    @(negedge clk);
    dp_rd = rd; dp_wr = !rd; dp_size = sz; dp_wdata = wd;
    @(negedge clk);
    dp_rd = 1'b0; dp_wr = 1'b0;
    for (int k = 1; k <= tot; k++) begin
      @(negedge clk);
      got_p += int'(rdc_pulse);
      if (k < tot) begin
        check({req, " R12"}, "busy during access", {31'b0, dp_busy}, 32'd1);
        check({req, " R12"}, "no early rvalid", {31'b0, dp_rvalid}, 32'd0);
      end
    end
    check({req, " R12"}, "busy ends", {31'b0, dp_busy}, 32'd0);
    check({req, " R12"}, "rvalid at end", {31'b0, dp_rvalid}, {31'b0, rd});
    if (rd) check({req, " R4"}, "read data", dp_rdata, exp_q);
    check({req, " R3"}, "pointer", {16'h0, cur_addr}, {16'h0, m_addr});
    check({req, " R3"}, "count", {16'h0, cur_count}, {16'h0, m_cnt});
    check({req, " R5"}, "completion pulses", 32'(got_p), 32'(exp_p));
  endtask

  task automatic t_reset;
    check("R1", "pointer", {16'h0, cur_addr}, 32'h0);
    check("R1", "count", {16'h0, cur_count}, 32'h0);
    check("R1", "busy", {31'b0, dp_busy}, 32'h0);
    check("R1", "rvalid", {31'b0, dp_rvalid}, 32'h0);
    check("R1", "rdc", {31'b0, rdc_pulse}, 32'h0);
    set_ptr(16'h7FFF, 16'h0005);
    xfer(1'b0, 2'd0, 32'h0000_00E7, "R1 reset ring");
    check("R1", "reset ring wraps 0x7FFF", {16'h0, cur_addr}, 32'h4000);
  endtask

  task automatic t_load;
    wr_reg(3'd4, 8'h34); wr_reg(3'd5, 8'h12);
    check("R2", "pointer pair", {16'h0, cur_addr}, 32'h1234);
    wr_reg(3'd4, 8'h56);
    check("R2", "pointer low keeps high", {16'h0, cur_addr}, 32'h1256);
    wr_reg(3'd7, 8'hAB); wr_reg(3'd6, 8'hCD);
    check("R2", "count pair", {16'h0, cur_count}, 32'hABCD);
    wr_reg(3'd7, 8'h01);
    check("R2", "count high keeps low", {16'h0, cur_count}, 32'h01CD);
  endtask

  task automatic t_bytes;
    set_ptr(16'h4000, 16'h0003);
    xfer(1'b0, 2'd0, 32'h0000_00A1, "R3 byte wr");
    xfer(1'b0, 2'd0, 32'h0000_00B2, "R3 byte wr");
    xfer(1'b0, 2'd0, 32'h0000_00C3, "R5 last byte wr");
    set_ptr(16'h4000, 16'h0003);
    xfer(1'b1, 2'd0, 32'h0, "R4 byte rd");
    xfer(1'b1, 2'd0, 32'h0, "R4 byte rd");
    xfer(1'b1, 2'd0, 32'h0, "R4 R5 byte rd");
  endtask

  task automatic t_wrap;
    wr_reg(3'd2, 8'h42);
    set_ptr(16'h41FE, 16'h0008);
    xfer(1'b0, 2'd2, 32'h4433_2211, "R6 R8 wrap wr");
    check("R6", "pointer after wrap", {16'h0, cur_addr}, 32'h4002);
    set_ptr(16'h41FE, 16'h0008);
    xfer(1'b1, 2'd2, 32'h0, "R6 R8 wrap rd");
    check("R8", "lane order", dp_rdata, 32'h4433_2211);
    set_ptr(16'h4000, 16'h0002);
    xfer(1'b1, 2'd0, 32'h0, "R6 byte after wrap");
    check("R6", "byte at 0x4000", dp_rdata, 32'h0000_0033);
    wr_reg(3'd2, 8'h80);
  endtask

  task automatic t_word;
    wr_reg(3'd3, 8'h00);
    set_ptr(16'h4010, 16'h000A);
    xfer(1'b0, 2'd1, 32'h0000_BBAA, "R7 16-bit byte mode");
    check("R7", "one byte moved", {16'h0, cur_addr}, 32'h4011);
    wr_reg(3'd3, 8'h01);
    xfer(1'b0, 2'd1, 32'h0000_DDCC, "R7 16-bit word mode");
    check("R7", "two bytes moved", {16'h0, cur_addr}, 32'h4013);
    set_ptr(16'h4011, 16'h0004);
    xfer(1'b1, 2'd1, 32'h0, "R7 word read");
    check("R7", "low byte first", dp_rdata, 32'h0000_DDCC);
    wr_reg(3'd3, 8'h00);
  endtask

  task automatic t_unmapped;
    set_ptr(16'h0011, 16'h0005);
    xfer(1'b0, 2'd0, 32'h0000_0099, "R9 drop 0x0011");
    check("R9", "pointer held", {16'h0, cur_addr}, 32'h0011);
    check("R9", "count held", {16'h0, cur_count}, 32'h0005);
    set_ptr(16'h3FFF, 16'h0005);
    xfer(1'b0, 2'd2, 32'h1234_5678, "R9 drop 0x3FFF");
    check("R9", "pointer held wide", {16'h0, cur_addr}, 32'h3FFF);
    set_ptr(16'h0010, 16'h0005);
    xfer(1'b0, 2'd0, 32'h0000_005A, "R9 edge 0x0010");
    check("R9", "edge byte stored", {16'h0, cur_addr}, 32'h0011);
    set_ptr(16'h0010, 16'h0005);
    xfer(1'b1, 2'd0, 32'h0, "R9 readback 0x0010");
    check("R9", "edge byte data", dp_rdata, 32'h0000_005A);
  endtask

  task automatic t_kick;
    set_ptr(16'h4000, 16'h0000);
    wr_reg(3'd0, 8'h08);
    check("R10", "kick read dir", {31'b0, last_rdc}, 32'h1);
    wr_reg(3'd0, 8'h10);
    check("R10", "kick write dir", {31'b0, last_rdc}, 32'h1);
    wr_reg(3'd0, 8'h19);
    check("R10", "stopped no kick", {31'b0, last_rdc}, 32'h0);
    wr_reg(3'd0, 8'h20);
    check("R10", "no dir no kick", {31'b0, last_rdc}, 32'h0);
    wr_reg(3'd6, 8'h02);
    wr_reg(3'd0, 8'h08);
    check("R10", "count nonzero no kick", {31'b0, last_rdc}, 32'h0);
  endtask

  task automatic t_saturate;
    set_ptr(16'h4100, 16'h0001);
    xfer(1'b0, 2'd3, 32'hCAFE_F00D, "R11 R8 size3 sat");
    check("R11", "count floor", {16'h0, cur_count}, 32'h0);
    check("R11", "pointer still moves", {16'h0, cur_addr}, 32'h4104);
    xfer(1'b0, 2'd0, 32'h0000_0011, "R11 byte at zero");
    check("R11", "no wrap below zero", {16'h0, cur_count}, 32'h0);
  endtask

  task automatic t_overlap;
    set_ptr(16'h4200, 16'h0010);
    @(negedge clk);
    dp_wr = 1'b1; dp_size = 2'd2; dp_wdata = 32'h0102_0304;
    @(negedge clk);
    dp_wr = 1'b0;
    @(negedge clk);
    dp_wr = 1'b1; dp_size = 2'd0;
    @(negedge clk);
    dp_wr = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R12", "busy done", {31'b0, dp_busy}, 32'h0);
    check("R12", "strobe while busy ignored", {16'h0, cur_addr}, 32'h4204);
    check("R12", "count moved four", {16'h0, cur_count}, 32'h000C);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_load;
    t_bytes;
    t_wrap;
    t_word;
    t_unmapped;
    t_kick;
    t_saturate;
    t_overlap;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule